// File: doc/BRIEF.md
# Parallel Flash Command and Status Engine

This block is the device side of a byte-wide parallel flash command port. It samples the chip-enable, write-strobe and output-enable lines of an asynchronous-style bus in its own clock domain. From the pattern of writes it recognises two command sequences. A four-write sequence programs a single byte. A six-write sequence erases one 4 KB sector. Progress is reported through the read data itself, so the block needs no ready pin.

While an operation is busy, a read returns status instead of array data. Bit 7 holds the inverse of the byte being programmed, or 0 during an erase. Bit 6 flips on every read. All other bits read 0. The erase duration and the program duration are each a parameter count of clock cycles. Writes that arrive while an operation is busy are dropped.

The storage behind the port is a small behavioural array. It holds 2^OFF_BITS bytes for each sector.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset no operation is busy, and every array byte reads 0xFF.
- R2: The writes 0xAA to 0x5555, 0x55 to 0x2AAA, 0xA0 to 0x5555, and then D to address A store D at A.
- R3: The writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555 and 0x55@0x2AAA, followed by a sixth write of 0x30, set every byte of the selected sector to 0xFF.
- R4: The sector number is address bits [AW-1:12], taken when the sixth write strobe falls. The 0x30 byte is taken when that strobe rises, so a change of address while the strobe is low has no effect.
- R5: A write whose address or data does not match the expected step returns the sequence to idle, and no program or erase happens.
- R6: While a program is busy, bit 7 of a read is the inverse of bit 7 of the programmed byte.
- R7: While an erase is busy, bit 7 of a read is 0. After the erase, reads of the sector return 0xFF.
- R8: While an operation is busy, bit 6 changes between consecutive reads. Once the operation has ended, repeated reads return the same value.
- R9: Writes issued while an operation is busy are ignored. This includes a complete program sequence.
- R10: During a busy read, bits 5..0 are 0. When chip enable or output enable is high, dout is 0.
- R11: The array is indexed by {addr[AW-1:12], addr[OFF_BITS-1:0]}. Erasing one sector leaves every other sector unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or status |

## Verification
The hardest case to reach is the one where a six-write erase and other bus traffic overlap in time. The address has to move between the falling and rising edges of the last strobe. A whole program sequence then has to be issued while the erase timer is still running. The bench drives the last erase write with one sector address at the falling edge and a different sector address before the rising edge. It then issues a full program sequence to a third sector and polls status until the data returns. Finally it sweeps every byte of the array to confirm that only the first sector was erased and that the program write was dropped.

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine #(
  parameter int AW           = 16,
  parameter int SECT_LSB     = 12,
  parameter int OFF_BITS     = 2,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout
);
  localparam int SB    = AW - SECT_LSB;
  localparam int IW    = SB + OFF_BITS;
  localparam int DEPTH = 1 << IW;
  localparam int CMAX  = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CW    = $clog2(CMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PGM, S_E1, S_E2, S_E3} st_t;

  st_t           st;
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wa;
  logic [7:0]    pdata;
  logic [CW-1:0] cnt;
  logic          is_erase, tog, wr_q, rd_q;

  wire wr     = ~ce_n & ~we_n;
  wire rd     = ~ce_n & ~oe_n;
  wire wr_beg = wr & ~wr_q;
  wire wr_end = ~wr & wr_q;
  wire busy   = cnt != '0;
  wire at_a   = wa == AW'(16'h5555);
  wire at_b   = wa == AW'(16'h2AAA);
  wire [IW-1:0] ridx = {addr[AW-1:SECT_LSB], addr[OFF_BITS-1:0]};
  wire [IW-1:0] widx = {wa[AW-1:SECT_LSB], wa[OFF_BITS-1:0]};

  assign dout = !rd ? 8'h00 :
                busy ? {(is_erase ? 1'b0 : ~pdata[7]), tog, 6'b0} : mem[ridx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; wa <= '0; pdata <= '0; cnt <= '0;
      is_erase <= 1'b0; tog <= 1'b0; wr_q <= 1'b0; rd_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      wr_q <= wr;
      rd_q <= rd;
      if (rd_q && !rd && busy) tog <= ~tog;
      if (wr_beg) wa <= addr;
      if (busy) cnt <= cnt - 1'b1;
      else if (wr_end) begin
        st <= S_IDLE;
        case (st)
          S_IDLE: if (at_a && din == 8'hAA) st <= S_U1;
          S_U1:   if (at_b && din == 8'h55) st <= S_U2;
          S_U2:   if (at_a && din == 8'hA0) st <= S_PGM;
                  else if (at_a && din == 8'h80) st <= S_E1;
          S_PGM: begin
            mem[widx] <= din;
            pdata     <= din;
            is_erase  <= 1'b0;
            cnt       <= CW'(PROG_CYCLES);
          end
          S_E1:   if (at_a && din == 8'hAA) st <= S_E2;
          S_E2:   if (at_b && din == 8'h55) st <= S_E3;
          S_E3:   if (din == 8'h30) begin
            for (int i = 0; i < (1 << OFF_BITS); i++)
              mem[{wa[AW-1:SECT_LSB], OFF_BITS'(i)}] <= 8'hFF;
            is_erase <= 1'b1;
            cnt      <= CW'(ERASE_CYCLES);
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module flash_cmd_engine_chk #(parameter int CW = 7) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic [7:0]    dout,
  input logic [CW-1:0] cnt,
  input logic [2:0]    st,
  input logic          is_erase,
  input logic          tog
);
  a_r10_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |-> dout == 8'h00);
  a_r9_timer_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> cnt == $past(cnt) - 1'b1);
  a_r9_seq_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> st == 3'd0);
  a_r7_erase_status: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && cnt != '0 && is_erase) |-> (dout[7] == 1'b0 && dout[5:0] == 6'd0));
  a_r8_toggle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tog) |-> $past(cnt != '0));
endmodule

bind flash_cmd_engine flash_cmd_engine_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .dout(dout),
  .cnt(cnt), .st(st), .is_erase(is_erase), .tog(tog));

// File: tb/flash_cmd_engine_bench.sv
module flash_cmd_engine_bench;
  localparam int CLK = 10;
  logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1, oe_n = 1;
  logic [15:0] addr = '0;
  logic [7:0]  din = '0, dout;
  int nvec = 0, nerr = 0;

  flash_cmd_engine u_flash_cmd_engine (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .dout(dout));

  always #(CLK/2) clk = ~clk;

  initial begin
    #(CLK * 150000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  function automatic logic [15:0] ad(int s, int o);
    return 16'((s << 12) | o);
  endfunction
  function automatic logic [7:0] pat(int s, int o);
    return 8'((s * 4 + o) ^ 8'hC3);
  endfunction

  task automatic chk(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr2(logic [15:0] a1, logic [15:0] a2, logic [7:0] d);
    @(negedge clk); addr = a1; din = d; ce_n = 0; we_n = 0;
    @(negedge clk); addr = a2;
    @(negedge clk); we_n = 1;
    repeat (2) @(negedge clk); ce_n = 1;
  endtask
  task automatic wr(logic [15:0] a, logic [7:0] d);
    wr2(a, a, d);
  endtask
  task automatic rd(logic [15:0] a, output logic [7:0] v);
    addr = a; ce_n = 0; oe_n = 0;
    repeat (2) @(negedge clk); v = dout;
    oe_n = 1; ce_n = 1;
    @(negedge clk);
  endtask
  task automatic prog(logic [15:0] a, logic [7:0] d);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0); wr(a, d);
  endtask
  task automatic settle(logic [15:0] a, output logic [7:0] v);
    logic [7:0] p;
    rd(a, p);
    for (int k = 0; k < 40; k++) begin
      rd(a, v);
      if (v == p) return;
      p = v;
    end
  endtask

  initial begin
    logic [7:0] v, p;
    int nbusy;
    repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);

    for (int s = 0; s < 16; s += 5) begin
      rd(ad(s, 3), v); chk(v == 8'hFF, "R1 reset content", v, 8'hFF);
    end
    addr = 16'h0000; ce_n = 0; @(negedge clk);
    chk(dout == 8'h00, "R10 oe high", dout, 8'h00); ce_n = 1;

    for (int s = 0; s < 16; s++)
      for (int o = 0; o < 4; o++) begin
        prog(ad(s, o), pat(s, o));
        rd(ad(s, o), v);
        chk(v[7] == ~pat(s, o)[7] && v[5:0] == 6'd0, "R6 R10 program status",
            v, {~pat(s, o)[7], v[6], 6'd0});
        settle(ad(s, o), v);
        chk(v == pat(s, o), "R2 program data", v, pat(s, o));
      end

    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55);
    wr2(ad(5, 0), ad(9, 0), 8'h30);
    prog(ad(0, 0), 8'h00);
    nbusy = 0;
    rd(ad(5, 1), p);
    chk(p[7] == 1'b0 && p[5:0] == 6'd0, "R7 R10 erase status", p, {1'b0, p[6], 6'd0});
    if (p[7] == 1'b0) nbusy++;
    for (int k = 0; k < 40; k++) begin
      rd(ad(5, 1), v);
      if (v[7]) break;
      nbusy++;
      chk(v[6] != p[6], "R8 toggle while busy", v, {p[7], ~p[6], p[5:0]});
      p = v;
    end
    chk(nbusy >= 2, "R8 busy reads seen", 8'(nbusy), 8'd2);
    rd(ad(5, 1), v); rd(ad(5, 1), p);
    chk(v == 8'hFF && p == v, "R7 R8 settled after erase", p, 8'hFF);

    for (int s = 0; s < 16; s++)
      for (int o = 0; o < 4; o++) begin
        logic [7:0] e;
        e = (s == 5) ? 8'hFF : pat(s, o);
        rd(ad(s, o), v);
        chk(v == e, (s == 5) ? "R3 erased sector" : (s == 9) ? "R4 late address unused" :
            (s == 0 && o == 0) ? "R9 program during erase" : "R11 other sectors", v, e);
      end

    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h56); wr(16'h5555, 8'hA0); wr(ad(1, 1), 8'h00);
    rd(ad(1, 1), v); chk(v == pat(1, 1), "R5 bad unlock data", v, pat(1, 1));
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5554, 8'hA0); wr(ad(1, 2), 8'h00);
    rd(ad(1, 2), v); chk(v == pat(1, 2), "R5 bad third address", v, pat(1, 2));
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h54); wr(ad(1, 0), 8'h30);
    rd(ad(1, 0), v); chk(v == pat(1, 0), "R5 bad erase unlock", v, pat(1, 0));
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(ad(1, 0), 8'h31);
    rd(ad(1, 3), v); chk(v == pat(1, 3), "R5 bad erase command", v, pat(1, 3));

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule